// File: doc/BRIEF.md
# Command-Driven Serial Register Port

This block is the host-facing serial port of a measurement device. A host selects it with an active-low chip select, drives a serial clock and a data-in line, and reads back on a data-out line. Every transfer opens with an 8-bit command word sent MSB first. Register-access commands either write a 24-bit word into a small bank of internal registers or read a register back out. Reads may be cut short at any byte boundary.

While a read is shifting out, the port keeps decoding the data-in line in 8-bit groups. The host normally sends the no-operation command during a read. Any other valid command that arrives in a group takes effect at once. This lets the host chain a write or a second read onto the tail of a read without deselecting the port. Register 0 holds the device configuration. One of its bits triggers a software reset that clears the bank and is never stored.

All port inputs pass through two-stage synchronizers and are sampled in the system clock domain. The serial clock is edge-detected there. Data-in is taken on rising serial clock edges, and data-out changes on falling edges.

Top module: `cmd_serial_port`

## Requirements
- R1: After an asynchronous assertion of rst_ni, cfg_o is zero at once, soft_rst_o and sdo_oe_o are low, and every register reads back as zero.
- R2: A command byte with bit 7 = 0, bit 6 = 1, the register address in bits 5:1 and bit 0 = 0 is followed by exactly 24 data bits, MSB first. These bits are then written to the addressed register, and the port waits for a new command.
- R3: A command byte with bit 7 = 0, bit 6 = 0, the address in bits 5:1 and bit 0 = 0 makes the port shift the register out on sdo_o, MSB first. Each bit is valid before the rising serial clock edge on which the host samples it.
- R4: A read may be ended after 8 or 16 bits by raising chip select. The bits delivered are the upper bytes of the register, and the next transfer starts again with a command byte.
- R5: The no-operation bytes 0xFE and 0xFF sent during a read leave the read undisturbed.
- R6: During a read, each group of 8 bits received on data-in is decoded as a command. A write or read command in such a group takes effect immediately after its 8th bit, and the data bits already sent in that group are unchanged.
- R7: While chip select is high, sdo_oe_o is low and the serial clock and data-in have no effect. Raising chip select in the middle of a transfer discards it.
- R8: A write to register 0 reaches cfg_o no sooner than 4 and no later than 11 system clock cycles after the 32nd rising serial clock edge of the transfer.
- R9: Writing register 0 with bit 7 set clears every register to zero and pulses soft_rst_o for one cycle. Bit 7 always reads back as 0.
- R10: A command byte with bit 7 = 1 or bit 0 = 1, other than 0xFE and 0xFF, is ignored while the port waits for a command. A write to an address at or above the bank size changes nothing, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the port |
| sdo_o | output | 1 | Serial data out of the port |
| sdo_oe_o | output | 1 | Output enable for sdo_o (high-impedance when low) |
| cfg_o | output | 24 | Current configuration register value |
| soft_rst_o | output | 1 | One-cycle pulse on a software reset |

## Verification
A bit counter or command shifter that is out of step shows up quickly. The next readback has its bytes rotated, or the following command byte is taken as data, so the fault appears within one transfer. A wrong state after a chained command appears within the same chip-select window, as a missing or misplaced write seen on a later readback. A broken configuration pipeline shows up on cfg_o a few system clock cycles after the final serial clock edge of the transfer. A failed soft-reset clear shows up as nonzero data on the next read of any register.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
  localparam int unsigned DATA_W = 24;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {ST_CMD, ST_WDATA, ST_READ} seq_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ, OP_OTHER} op_e;

  function automatic op_e decode_cmd(input logic [CMD_W-1:0] c);
    if (c == 8'hFE || c == 8'hFF) return OP_NONE;
    if (c[7] || c[0])             return OP_OTHER;
    return c[6] ? OP_WRITE : OP_READ;
  endfunction
endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] ff [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) ff[s] <= RST_VAL;
    end else begin
      ff[0] <= d_i;
      for (int s = 1; s < STAGES; s++) ff[s] <= ff[s-1];
    end
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/port_regfile.sv
module port_regfile import cmd_port_pkg::*; #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned CFG_DLY  = 3,
  parameter int unsigned RST_BIT  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              soft_rst_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [CFG_DLY-1:0] pv;
  logic [DATA_W-1:0] pd [CFG_DLY];
  logic cfg_wr, cfg_load, soft_clr, soft_q;
  logic [DATA_W-1:0] cfg_new;

  assign cfg_wr   = wr_valid_i && (wr_addr_i == '0);
  assign cfg_load = pv[CFG_DLY-1];
  assign cfg_new  = pd[CFG_DLY-1];
  assign soft_clr = cfg_load && cfg_new[RST_BIT];

  // models the cross-domain load delay of the configuration word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv <= '0;
      for (int s = 0; s < CFG_DLY; s++) pd[s] <= '0;
    end else begin
      pv[0] <= cfg_wr;
      pd[0] <= wr_data_i;
      for (int s = 1; s < CFG_DLY; s++) begin
        pv[s] <= pv[s-1];
        pd[s] <= pd[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      soft_q <= 1'b0;
    end else begin
      soft_q <= soft_clr;
      if (soft_clr) begin
        for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else begin
        if (cfg_load) regs[0] <= cfg_new;
        for (int i = 1; i < NUM_REGS; i++)
          if (wr_valid_i && wr_addr_i == ADDR_W'(i)) regs[i] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs[i];
  end

  assign cfg_o      = regs[0];
  assign soft_rst_o = soft_q;

  // R8: configuration moves only when the delay pipe delivers
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load |=> $stable(cfg_o));
  // R9: a soft reset leaves the bank cleared
  p_soft_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (cfg_o == '0 && regs[NUM_REGS-1] == '0));
endmodule

// File: rtl/port_seq.sv
module port_seq import cmd_port_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  seq_state_e state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CMD_W-1:0]  cmd_sh, cmd_next;
  logic [DATA_W-1:0] in_sh, out_sh;
  logic [ADDR_W-1:0] cur_addr;
  logic sclk_d, rise, fall, shift_pend;
  op_e  op;

  assign rise     = sclk_i & ~sclk_d;
  assign fall     = ~sclk_i & sclk_d;
  assign cmd_next = {cmd_sh[CMD_W-2:0], sdi_i};
  assign op       = decode_cmd(cmd_next);
  assign rd_addr_o = cmd_next[ADDR_W:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_CMD;
      bit_cnt    <= '0;
      cmd_sh     <= '0;
      in_sh      <= '0;
      out_sh     <= '0;
      cur_addr   <= '0;
      shift_pend <= 1'b0;
      sclk_d     <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      sclk_d     <= sclk_i;
      wr_valid_o <= 1'b0;
      if (!cs_act_i) begin
        state      <= ST_CMD;
        bit_cnt    <= '0;
        shift_pend <= 1'b0;
      end else begin
        // data-out advances only on a fall that follows a sampling rise
        if (fall && shift_pend) begin
          out_sh     <= {out_sh[DATA_W-2:0], 1'b0};
          shift_pend <= 1'b0;
        end
        if (rise) begin
          unique case (state)
            ST_CMD: begin
              cmd_sh <= cmd_next;
              if (bit_cnt == CMD_LAST) begin
                bit_cnt <= '0;
                if (op == OP_WRITE) begin
                  state    <= ST_WDATA;
                  cur_addr <= cmd_next[ADDR_W:1];
                end else if (op == OP_READ) begin
                  state  <= ST_READ;
                  out_sh <= rd_data_i;
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
            ST_WDATA: begin
              in_sh <= {in_sh[DATA_W-2:0], sdi_i};
              if (bit_cnt == DATA_LAST) begin
                bit_cnt    <= '0;
                state      <= ST_CMD;
                wr_valid_o <= 1'b1;
                wr_addr_o  <= cur_addr;
                wr_data_o  <= {in_sh[DATA_W-2:0], sdi_i};
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
            ST_READ: begin
              cmd_sh     <= cmd_next;
              shift_pend <= 1'b1;
              if (bit_cnt == CMD_LAST) begin
                bit_cnt <= '0;
                unique case (op)
                  OP_WRITE: begin
                    state      <= ST_WDATA;
                    cur_addr   <= cmd_next[ADDR_W:1];
                    shift_pend <= 1'b0;
                  end
                  OP_READ: begin
                    out_sh     <= rd_data_i;
                    shift_pend <= 1'b0;
                  end
                  OP_OTHER: begin
                    state      <= ST_CMD;
                    shift_pend <= 1'b0;
                  end
                  default: ;
                endcase
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
            default: state <= ST_CMD;
          endcase
        end
      end
    end
  end

  assign sdo_o = (state == ST_READ) ? out_sh[DATA_W-1] : 1'b0;

  // R7: deselect always returns the sequencer to the command phase
  p_idle_after_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (state == ST_CMD && bit_cnt == '0));
  // R2: a register write is issued only at the end of a data phase
  p_wr_from_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(state) == ST_WDATA);
  // R6: reads decode commands on byte boundaries
  p_read_byte_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_READ) |-> (bit_cnt <= CMD_LAST));
  // R2: the bit counter never runs past a data word
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= DATA_LAST);
endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port import cmd_port_pkg::*; #(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_DLY     = 3,
  parameter int unsigned RST_BIT     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              soft_rst_o
);
  logic cs_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic wr_valid;

  port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  port_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_act_i  (~cs_s),
    .sclk_i    (sclk_s),
    .sdi_i     (sdi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_valid_o(wr_valid),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo_o)
  );

  port_regfile #(.NUM_REGS(NUM_REGS), .CFG_DLY(CFG_DLY), .RST_BIT(RST_BIT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(wr_valid),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .cfg_o     (cfg_o),
    .soft_rst_o(soft_rst_o)
  );

  assign sdo_oe_o = ~cs_s;
endmodule

// File: tb/tb_cmd_serial_port.sv
module tb_cmd_serial_port;
  localparam int NREG = 8;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, soft_rst;
  logic [23:0] cfg;
  int n_chk = 0, n_fail = 0, soft_pulses = 0;
  bit done = 1'b0;
  logic [23:0] model [NREG];

  always #4 clk = ~clk;

  cmd_serial_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg), .soft_rst_o(soft_rst)
  );

  always @(posedge clk) if (soft_rst) soft_pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic o);
    @(negedge clk) sdi = b;
    wait_clk(HALF);
    o = sdo;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i]);
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(16);
  endtask

  function automatic logic [7:0] wcmd(input int a);
    return {2'b01, 5'(a), 1'b0};
  endfunction
  function automatic logic [7:0] rcmd(input int a);
    return {2'b00, 5'(a), 1'b0};
  endfunction

  function automatic void model_write(input int a, input logic [23:0] d);
    if (a >= NREG) return;
    if (a == 0 && d[7]) begin
      for (int i = 0; i < NREG; i++) model[i] = '0;
    end else begin
      model[a] = d;
    end
  endfunction

  task automatic write_reg(input int a, input logic [23:0] d);
    logic [7:0] rx;
    select();
    byte_io(wcmd(a), rx);
    byte_io(d[23:16], rx);
    byte_io(d[15:8], rx);
    byte_io(d[7:0], rx);
    deselect();
    model_write(a, d);
  endtask

  task automatic read_reg(input int a, input int nbytes, input logic [7:0] nop,
                          output logic [23:0] got);
    logic [7:0] rx;
    select();
    byte_io(rcmd(a), rx);
    got = '0;
    for (int k = 0; k < nbytes; k++) begin
      byte_io(nop, rx);
      got = {got[15:0], rx};
    end
    deselect();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [23:0] got, pat, old;
    logic [7:0] r0, r1, r2;
    logic o;
    int sp;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    wait_clk(5);
    // R1: reset state
    check("R1 oe", sdo_oe, 1'b0);
    check("R1 cfg", cfg, 24'h0);
    check("R1 soft", soft_rst, 1'b0);
    rst_n = 1'b1;
    wait_clk(5);
    read_reg(3, 3, 8'hFE, got);
    check("R1 reg3", got, 24'h0);

    // R2 R3 R5: write every register, read back full width, alternating NOP codes
    write_reg(0, 24'h3C1D40);
    for (int i = 1; i < NREG; i++) begin
      pat = (24'(i) * 24'h13579B) ^ (24'hA5A5A5 >> i);
      write_reg(i, pat);
    end
    for (int i = 0; i < NREG; i++) begin
      read_reg(i, 3, (i % 2 == 0) ? 8'hFE : 8'hFF, got);
      check($sformatf("R2/R3/R5 reg%0d", i), got, model[i]);
    end
    check("R2 cfg_o", cfg, 24'h3C1D40);

    // R4: truncated reads, then a full read still works
    read_reg(5, 1, 8'hFE, got);
    check("R4 8-bit", got, {16'h0, model[5][23:16]});
    read_reg(6, 2, 8'hFF, got);
    check("R4 16-bit", got, {8'h0, model[6][23:8]});
    read_reg(6, 3, 8'hFE, got);
    check("R4 full after truncation", got, model[6]);

    // R6: read then chained write in the last byte
    select();
    byte_io(rcmd(2), r0);
    byte_io(8'hFE, r0);
    byte_io(8'hFE, r1);
    byte_io(wcmd(3), r2);
    check("R6 read before chain", {r0, r1, r2}, model[2]);
    byte_io(8'h9E, r0);
    byte_io(8'h42, r0);
    byte_io(8'h17, r0);
    deselect();
    model_write(3, 24'h9E4217);
    read_reg(3, 3, 8'hFE, got);
    check("R6 chained write", got, 24'h9E4217);

    // R6: read chained onto a read after one byte
    select();
    byte_io(rcmd(1), r0);
    byte_io(rcmd(4), r0);
    check("R6 first byte", r0, model[1][23:16]);
    byte_io(8'hFE, r0);
    byte_io(8'hFE, r1);
    byte_io(8'hFE, r2);
    deselect();
    check("R6 chained read", {r0, r1, r2}, model[4]);

    // R7: chip select high blocks traffic
    check("R7 oe idle", sdo_oe, 1'b0);
    pat = 24'h0F0F0F;
    for (int i = 7; i >= 0; i--) bit_io(wcmd(5) >> i, o);
    for (int i = 23; i >= 0; i--) bit_io(pat[i], o);
    check("R7 oe during", sdo_oe, 1'b0);
    read_reg(5, 3, 8'hFE, got);
    check("R7 ignored while deselected", got, model[5]);
    select();
    check("R7 oe selected", sdo_oe, 1'b1);
    byte_io(wcmd(5), r0);
    byte_io(8'hAA, r0);
    for (int i = 0; i < 4; i++) bit_io(1'b1, o);
    deselect();
    read_reg(5, 3, 8'hFF, got);
    check("R7 aborted write", got, model[5]);

    // R8: configuration load delay
    old = cfg;
    pat = 24'h5A6B3C;
    select();
    byte_io(wcmd(0), r0);
    byte_io(pat[23:16], r0);
    byte_io(pat[15:8], r0);
    for (int i = 7; i >= 1; i--) bit_io(pat[i], o);
    @(negedge clk) sdi = pat[0];
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(3);
    check("R8 not yet", cfg, old);
    wait_clk(8);
    check("R8 loaded", cfg, pat);
    sclk = 1'b0;
    deselect();
    model_write(0, pat);

    // R10: odd or high-bit commands ignored; out-of-range address
    select();
    byte_io(8'h41, r0);
    byte_io(8'hC3, r0);
    byte_io(8'h99, r0);
    byte_io(8'hE7, r0);
    deselect();
    check("R10 odd command ignored", cfg, model[0]);
    write_reg(9, 24'hFFFFFF);
    read_reg(9, 3, 8'hFE, got);
    check("R10 out-of-range read", got, 24'h0);
    for (int i = 0; i < NREG; i++) begin
      read_reg(i, 3, 8'hFE, got);
      check($sformatf("R10 bank intact reg%0d", i), got, model[i]);
    end

    // R9: software reset
    sp = soft_pulses;
    write_reg(0, 24'h1234C5);
    check("R9 one pulse", soft_pulses - sp, 1);
    check("R9 cfg cleared", cfg, 24'h0);
    for (int i = 0; i < NREG; i++) begin
      read_reg(i, 3, 8'hFE, got);
      check($sformatf("R9 reg%0d cleared", i), got, model[i]);
    end

    // R1: asynchronous reset clears without a clock edge
    write_reg(0, 24'h00FF7F);
    write_reg(2, 24'hBEEF01);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async cfg", cfg, 24'h0);
    check("R1 async oe", sdo_oe, 1'b0);
    for (int i = 0; i < NREG; i++) model[i] = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    read_reg(2, 3, 8'hFE, got);
    check("R1 async reg2", got, 24'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule